// File: doc/BRIEF.md
# Registered command path with bypass

This block sits on the address and control path between a memory controller and a set of SDRAM devices. It carries the row/column address, bank select, chip selects, clock enable, the RAS/CAS/WE strobes and the per-byte data masks. A mode pin selects one of two paths. In the latched path, every signal is captured on the rising clock edge and held for one cycle. In the flow path, every signal passes through combinationally. The data and check-bit buses do not pass through this block.

The chip selects and clock enable leave the block as identical copies, one copy per device group. A status output gives the extra command latency the block adds: 1 in the latched path and 0 in the flow path. A controller model adds this value to the CAS latency when it captures read data. In the latched path, the controller must send write data one cycle after the write command.

A two-state machine chooses the path. `PS_LATCHED` is the reset state, so a board pull-up that leaves the mode pin high keeps the block latched. `PS_FLOW` is the bypass state. Transition `T_TO_FLOW` fires on a clock edge when the mode pin is low and every chip select is high. Transition `T_TO_LATCHED` fires on a clock edge when the mode pin is high and every chip select is high. In every other case the state holds, so a path change only happens between commands.

Top module: `ctl_regbuf`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, the latched outputs show an inactive command: every chip select 1, RAS/CAS/WE 1, clock enable 0, and address, bank and masks 0.
- R2: In the latched path, every output equals the value its input had at the previous rising edge.
- R3: In the flow path, every output equals its input in the same cycle.
- R4: `lat_added_o` is 1 in `PS_LATCHED` and 0 in `PS_FLOW`.
- R5: The path changes only at an edge where all `cs_n_i` bits are 1. A mode pin change seen while any chip select is 0 is held off until such an edge.
- R6: Reset always enters `PS_LATCHED`, whatever the level of the mode pin.
- R7: All GROUPS copies of the chip-select vector (copy g at bits g*CS_W and up of `cs_n_o`) and of clock enable (bit g of `cke_o`) carry the same value.
- R8: The byte masks take the same path and the same delay as the address and strobes.
- R9: Clock enable is carried like any other field. A low clock enable does not stop capture and does not freeze the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_reg_i | input | 1 | 1 requests the latched path, 0 requests the flow path |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| bank_i | input | BANK_W | Bank select |
| cs_n_i | input | CS_W | Active-low chip selects |
| cke_i | input | 1 | Clock enable |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| dqm_i | input | DQM_W | Byte masks |
| addr_o | output | ADDR_W | Address to devices |
| bank_o | output | BANK_W | Bank select to devices |
| cs_n_o | output | GROUPS*CS_W | Chip-select copies, one per group |
| cke_o | output | GROUPS | Clock-enable copies, one per group |
| ras_n_o | output | 1 | Row strobe to devices |
| cas_n_o | output | 1 | Column strobe to devices |
| we_n_o | output | 1 | Write strobe to devices |
| dqm_o | output | DQM_W | Byte masks to devices |
| lat_added_o | output | 1 | Extra command latency (0 or 1) |

## Verification
Two things can happen in the same cycle: a path-change request and an active command. The bench flips the mode pin while chip selects are still low. It expects the old path and the old latency value to hold until the first cycle in which every chip select is high. That idle cycle is also the last one the register captures before the path swaps. The scoreboard therefore checks the cycles on both sides of every switch, and confirms that no command is dropped or shown twice.

// File: rtl/cmdreg_pkg.sv
`timescale 1ns/1ps
package cmdreg_pkg;

    // Path selection states
    typedef enum logic {
        PS_FLOW    = 1'b0,
        PS_LATCHED = 1'b1
    } path_state_e;

    // Transition labels
    typedef enum logic [1:0] {
        T_HOLD       = 2'd0,
        T_TO_FLOW    = 2'd1,
        T_TO_LATCHED = 2'd2
    } path_trans_e;

endpackage

// File: rtl/cmdreg_mode_fsm.sv
`timescale 1ns/1ps
module cmdreg_mode_fsm
    import cmdreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_req_i,
    input  logic bus_idle_i,
    output logic latched_o
);

    path_state_e state_q;
    path_state_e state_d;
    path_trans_e trans;

    always_comb begin
        trans   = T_HOLD;
        state_d = state_q;
        unique case (state_q)
            PS_LATCHED: begin
                if (!mode_req_i && bus_idle_i) begin
                    trans   = T_TO_FLOW;
                    state_d = PS_FLOW;
                end
            end
            PS_FLOW: begin
                if (mode_req_i && bus_idle_i) begin
                    trans   = T_TO_LATCHED;
                    state_d = PS_LATCHED;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_LATCHED;
        else        state_q <= state_d;
    end

    always_comb begin
        latched_o = (state_q == PS_LATCHED);
    end

    // R5: a state change is only allowed after an idle bus cycle
    a_r5_switch_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (state_q != $past(state_q))) |-> $past(bus_idle_i));

    // R6: the first cycle after reset is always latched
    a_r6_latched_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (state_q == PS_LATCHED));

endmodule

// File: rtl/cmdreg_stage.sv
`timescale 1ns/1ps
module cmdreg_stage #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= RST_VAL;
        else        q_o <= d_i;
    end

    // R1: the stage holds the inactive command right after reset
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (q_o == RST_VAL));

endmodule

// File: rtl/cmdreg_fanout.sv
`timescale 1ns/1ps
module cmdreg_fanout #(
    parameter int CS_W   = 4,
    parameter int GROUPS = 4
) (
    input  logic [CS_W-1:0]        cs_n_i,
    input  logic                   cke_i,
    output logic [GROUPS*CS_W-1:0] cs_n_o,
    output logic [GROUPS-1:0]      cke_o
);

    for (genvar g = 0; g < GROUPS; g++) begin : g_copy
        assign cs_n_o[g*CS_W +: CS_W] = cs_n_i;
        assign cke_o[g]               = cke_i;
    end

endmodule

// File: rtl/ctl_regbuf.sv
`timescale 1ns/1ps
module ctl_regbuf #(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2,
    parameter int CS_W   = 4,
    parameter int DQM_W  = 8,
    parameter int GROUPS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mode_reg_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [BANK_W-1:0]      bank_i,
    input  logic [CS_W-1:0]        cs_n_i,
    input  logic                   cke_i,
    input  logic                   ras_n_i,
    input  logic                   cas_n_i,
    input  logic                   we_n_i,
    input  logic [DQM_W-1:0]       dqm_i,
    output logic [ADDR_W-1:0]      addr_o,
    output logic [BANK_W-1:0]      bank_o,
    output logic [GROUPS*CS_W-1:0] cs_n_o,
    output logic [GROUPS-1:0]      cke_o,
    output logic                   ras_n_o,
    output logic                   cas_n_o,
    output logic                   we_n_o,
    output logic [DQM_W-1:0]       dqm_o,
    output logic                   lat_added_o
);

    localparam int LOW_W = BANK_W + ADDR_W + DQM_W;
    localparam int CMD_W = CS_W + 4 + LOW_W;
    localparam logic [CMD_W-1:0] IDLE_CMD =
        {{CS_W{1'b1}}, 1'b0, 3'b111, {LOW_W{1'b0}}};

    logic [CMD_W-1:0] cmd_in;
    logic [CMD_W-1:0] cmd_q;
    logic [CMD_W-1:0] cmd_sel;
    logic             latched;
    logic [CS_W-1:0]  cs_n_sel;
    logic             cke_sel;

    assign cmd_in = {cs_n_i, cke_i, ras_n_i, cas_n_i, we_n_i, bank_i, addr_i, dqm_i};

    cmdreg_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_req_i (mode_reg_i),
        .bus_idle_i (&cs_n_i),
        .latched_o  (latched)
    );

    cmdreg_stage #(
        .W       (CMD_W),
        .RST_VAL (IDLE_CMD)
    ) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmd_in),
        .q_o   (cmd_q)
    );

    always_comb begin
        cmd_sel = latched ? cmd_q : cmd_in;
    end

    assign {cs_n_sel, cke_sel, ras_n_o, cas_n_o, we_n_o, bank_o, addr_o, dqm_o} = cmd_sel;
    assign lat_added_o = latched;

    cmdreg_fanout #(
        .CS_W   (CS_W),
        .GROUPS (GROUPS)
    ) u_fanout (
        .cs_n_i (cs_n_sel),
        .cke_i  (cke_sel),
        .cs_n_o (cs_n_o),
        .cke_o  (cke_o)
    );

    // R2 / R8: latched path delays address, strobes and masks by one edge
    a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && lat_added_o) |->
            (addr_o == $past(addr_i) && ras_n_o == $past(ras_n_i) &&
             we_n_o == $past(we_n_i) && dqm_o == $past(dqm_i)));

    // R3: flow path passes inputs in the same cycle
    a_r3_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_added_o |-> (addr_o == addr_i && cas_n_o == cas_n_i &&
                          cs_n_o[CS_W-1:0] == cs_n_i && dqm_o == dqm_i));

endmodule

// File: tb/test_ctl_regbuf.sv
`timescale 1ns/1ps
module test_ctl_regbuf;

    localparam int AW = 13;
    localparam int BW = 2;
    localparam int CW = 4;
    localparam int MW = 8;
    localparam int G  = 4;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [BW-1:0] b;
        logic [CW-1:0] cs;
        logic          ck;
        logic          r;
        logic          c;
        logic          w;
        logic [MW-1:0] m;
    } cmd_t;

    typedef struct packed {
        cmd_t c;
        logic lat;
    } exp_t;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic mode_pin = 1'b1;
    cmd_t cur_in;

    logic [AW-1:0]   addr_o;
    logic [BW-1:0]   bank_o;
    logic [G*CW-1:0] cs_n_o;
    logic [G-1:0]    cke_o;
    logic            ras_n_o, cas_n_o, we_n_o;
    logic [MW-1:0]   dqm_o;
    logic            lat_added_o;

    ctl_regbuf #(.ADDR_W(AW), .BANK_W(BW), .CS_W(CW), .DQM_W(MW), .GROUPS(G)) i_ctl_regbuf (
        .clk(clk), .rst_n(rst_n), .mode_reg_i(mode_pin),
        .addr_i(cur_in.a), .bank_i(cur_in.b), .cs_n_i(cur_in.cs), .cke_i(cur_in.ck),
        .ras_n_i(cur_in.r), .cas_n_i(cur_in.c), .we_n_i(cur_in.w), .dqm_i(cur_in.m),
        .addr_o(addr_o), .bank_o(bank_o), .cs_n_o(cs_n_o), .cke_o(cke_o),
        .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o), .dqm_o(dqm_o),
        .lat_added_o(lat_added_o)
    );

    int   n_chk  = 0;
    int   n_fail = 0;
    exp_t q_exp[$];
    string q_tag[$];
    cmd_t prev_in;
    logic model_reg;

    function automatic cmd_t idle_cmd();
        cmd_t k;
        k = '0;
        k.cs = '1; k.r = 1'b1; k.c = 1'b1; k.w = 1'b1; k.ck = 1'b0;
        return k;
    endfunction

    function automatic cmd_t mk(input int i, input logic busy, input logic ck);
        cmd_t k;
        k.a  = AW'(13'h1A5 ^ (i * 13'h123));
        k.b  = BW'(i);
        k.cs = busy ? ~(CW'(1) << (i % CW)) : '1;
        k.ck = ck;
        k.r  = i[0]; k.c = i[1]; k.w = i[2];
        k.m  = MW'(8'h0F << (i % MW)) ^ MW'(i);
        return k;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic cmd_t got_cmd();
        cmd_t k;
        k.a = addr_o; k.b = bank_o; k.cs = cs_n_o[CW-1:0]; k.ck = cke_o[0];
        k.r = ras_n_o; k.c = cas_n_o; k.w = we_n_o; k.m = dqm_o;
        return k;
    endfunction

    // Driver: apply stimulus at the falling edge and push the expectation
    task automatic step(input cmd_t c, input logic m, input string tag);
        exp_t e;
        @(negedge clk);
        cur_in   = c;
        mode_pin = m;
        e.c   = model_reg ? prev_in : c;
        e.lat = model_reg;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        prev_in = c;
        if (&c.cs) model_reg = m;
    endtask

    // Monitor: compare outputs 2 ns after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q_exp.size() != 0) begin
                exp_t  e;
                string t;
                cmd_t  g;
                bit    copies_ok;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                g = got_cmd();
                chk(g == e.c, t, "command", 64'(g), 64'(e.c));
                chk(lat_added_o == e.lat, t, "latency R4", 64'(lat_added_o), 64'(e.lat));
                copies_ok = 1'b1;
                for (int gi = 0; gi < G; gi++)
                    if (cs_n_o[gi*CW +: CW] != e.c.cs || cke_o[gi] != e.c.ck) copies_ok = 1'b0;
                chk(copies_ok, "R7", "group copies", 64'(cs_n_o), 64'(e.c.cs));
            end
        end
    end

    task automatic do_reset(input logic m);
        @(negedge clk);
        rst_n    = 1'b0;
        cur_in   = idle_cmd();
        mode_pin = m;
        repeat (2) @(negedge clk);
        #1;
        chk(got_cmd() == idle_cmd(), "R1", "inactive in reset", 64'(got_cmd()), 64'(idle_cmd()));
        chk(lat_added_o == 1'b1, "R6", "latched in reset", 64'(lat_added_o), 64'd1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(lat_added_o == 1'b1, "R6", "latched after release", 64'(lat_added_o), 64'd1);
        chk(got_cmd() == idle_cmd(), "R1", "inactive after release", 64'(got_cmd()), 64'(idle_cmd()));
        // model the edge between release and the first driven step
        prev_in   = cur_in;
        model_reg = 1'b1;
        if (&cur_in.cs) model_reg = m;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cur_in    = idle_cmd();
        prev_in   = idle_cmd();
        model_reg = 1'b1;
        do_reset(1'b1);

        // R2: latched path, busy commands of varied shape
        for (int i = 0; i < 6; i++) step(mk(i, 1'b1, 1'b1), 1'b1, "R2");
        // R8: mask-only changes on an idle bus in the latched path
        for (int i = 0; i < 4; i++) begin
            cmd_t k;
            k = idle_cmd();
            k.ck = 1'b1;
            k.m = MW'(8'hA5 >> i) ^ MW'(8'h3C << i);
            step(k, 1'b1, "R8");
        end
        // R5: request flow path while the bus is busy: must stay latched
        for (int i = 0; i < 3; i++) step(mk(i + 10, 1'b1, 1'b1), 1'b0, "R5");
        step(idle_cmd(), 1'b0, "R5");
        // R3: flow path
        for (int i = 0; i < 6; i++) step(mk(i + 20, 1'b1, 1'b1), 1'b0, "R3");
        // R9: clock enable toggling in the flow path
        for (int i = 0; i < 4; i++) step(mk(i + 30, 1'b1, i[0]), 1'b0, "R9");
        // R5: request latched path while busy, then on idle
        for (int i = 0; i < 2; i++) step(mk(i + 40, 1'b1, 1'b1), 1'b1, "R5");
        step(idle_cmd(), 1'b1, "R5");
        // R2 and R9 back in the latched path
        for (int i = 0; i < 4; i++) step(mk(i + 50, 1'b1, i[1]), 1'b1, "R9");
        for (int i = 0; i < 3; i++) step(mk(i + 60, 1'b1, 1'b1), 1'b1, "R2");
        step(idle_cmd(), 1'b1, "R2");
        // R6: reset with the mode pin low still starts latched
        do_reset(1'b0);
        step(mk(70, 1'b1, 1'b1), 1'b0, "R6");
        for (int i = 0; i < 3; i++) step(mk(i + 71, 1'b1, 1'b1), 1'b0, "R3");
        step(idle_cmd(), 1'b0, "R3");
        repeat (2) @(negedge clk);
        #3;
        finish_run();
    end

endmodule